// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog counter behind a small 16-bit register bus. A 10-bit count falls by one on every single-cycle tick pulse. The tick pulse comes from outside, nominally one every 0.6 s. Software keeps the system alive by writing the reload register, which puts the count back to the programmed load value. If software stops doing so, the count reaches zero. The next tick is the first expiry. It reloads the counter, raises a timeout flag and, when enabled, an interrupt line.

If the counter runs out a second time while that flag is still set, the block records a second-timeout status. It also issues a one-cycle reset request, unless the no-reboot input is high. Clearing the first flag between expiries puts the sequence back to the first stage.

The counter comes out of reset halted, so nothing counts until software clears the halt bit. Load values below 4 are rejected.

Top module: `dew_watchdog`

## Requirements
- R1: After reset the count reads 4, the load register reads 0x0004, the control register reads 0x0800 (halted), both status registers read 0, and `rst_req_o` and `irq_o` are low.
- R2: While control bit 11 (halt) is 1, ticks change nothing. While it is 0, each tick lowers the count by one. The control register reads back bits 11 and 13 as written and reads 0 in every other bit.
- R3: Any write to offset 0x00 sets the count to the current load value, whatever the write data. A read of 0x00 returns the live count in bits [9:0] and zeros above.
- R4: A write to offset 0x12 whose bits [9:0] are 4 or more updates the load value from bits [9:0] and the 6-bit spare storage from bits [15:10]. The register reads back the full 16 bits. The live count is not changed by this write.
- R5: A write to offset 0x12 whose bits [9:0] are 0 to 3 is dropped completely. Both the load value and the spare bits keep their previous contents.
- R6: A tick that arrives while the count is 0 and halt is 0 is an expiry. On the same clock edge the count takes the load value and bit 3 of the status register at 0x04 becomes 1. A count of 0 by itself sets nothing.
- R7: Bit 3 at 0x04 clears only when a 1 is written to bit 3. A write with bit 3 equal to 0 leaves the bit unchanged.
- R8: An expiry while bit 3 at 0x04 is already 1 sets bit 1 at 0x06. If no-reboot is low, it also sets bit 2 at 0x06 (boot status) and drives `rst_req_o` high for exactly one cycle, on the clock edge that follows the expiry tick. Bit 3 at 0x04 stays 1.
- R9: With `no_reboot` high, a second expiry still sets bit 1 at 0x06. No reset pulse is issued and bit 2 is not set.
- R10: If bit 3 at 0x04 was cleared after the first expiry, the next expiry sets it again as a first-stage event, with no reset and no change at 0x06.
- R11: Bits 1 and 2 at 0x06 each clear only when a 1 is written to that bit.
- R12: `irq_o` equals bit 3 at 0x04 AND control bit 13 (interrupt enable).
- R13: A write to 0x00 on the same edge as a tick at count 0 wins. The count reloads and no expiry is recorded.
- R14: A read is registered. `bus_rdata` takes the addressed value on the clock edge where `bus_re` is high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count step pulse |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| no_reboot | input | 1 | Suppresses the reset request when high |
| irq_o | output | 1 | Timeout interrupt, level |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A wrong count shows up on the next read of 0x00. It also shows up as an expiry that lands a tick early or late, which the status registers reveal when they are next read. A first-timeout flag that is lost or stuck turns the second expiry into the wrong stage. That appears either as a missing or extra pulse on `rst_req_o` within one cycle of the expiry tick, or as the wrong value at 0x06. A faulty load register shows up at the next reload, either through 0x00 or through the timing of the expiry.

// File: rtl/dew_pkg.sv
`timescale 1ns/1ps
package dew_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;

  // register byte offsets (software decodes these)
  localparam logic [ADDR_W-1:0] OFS_RLD  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STS1 = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STS2 = 8'h06;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_INIT = 8'h12;

  // bit positions
  localparam int BIT_TO1   = 3;
  localparam int BIT_TO2   = 1;
  localparam int BIT_BOOT  = 2;
  localparam int BIT_HALT  = 11;
  localparam int BIT_IRQEN = 13;

  typedef struct packed {
    logic rld_wr;
    logic clr_to1;
    logic clr_to2;
    logic clr_boot;
  } dew_cmd_t;

  typedef struct packed {
    logic to1;
    logic to2;
    logic boot;
  } dew_flags_t;
endpackage

// File: rtl/dew_regs.sv
`timescale 1ns/1ps
module dew_regs
  import dew_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int LOAD_MIN = 4,
  parameter int LOAD_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  input  logic [CNT_W-1:0]  count,
  input  dew_flags_t        flags,
  output dew_cmd_t          cmd,
  output logic              halt,
  output logic              irq_en,
  output logic [CNT_W-1:0]  load,
  output logic [DATA_W-1:0] rdata
);
  localparam int SPARE_W = DATA_W - CNT_W;
  localparam logic [CNT_W-1:0] LOAD_FLOOR = CNT_W'(LOAD_MIN);
  localparam logic [CNT_W-1:0] LOAD_INIT  = CNT_W'(LOAD_RST);

  logic [SPARE_W-1:0] spare_q;
  logic               hit_rld, hit_sts1, hit_sts2, hit_ctl, hit_init;
  logic               load_ok;
  logic [DATA_W-1:0]  rd_mux;

  always_comb begin
    hit_rld  = we && (addr == OFS_RLD);
    hit_sts1 = we && (addr == OFS_STS1);
    hit_sts2 = we && (addr == OFS_STS2);
    hit_ctl  = we && (addr == OFS_CTL);
    hit_init = we && (addr == OFS_INIT);
    load_ok  = wdata[CNT_W-1:0] >= LOAD_FLOOR;
  end

  always_comb begin
    cmd.rld_wr   = hit_rld;
    cmd.clr_to1  = hit_sts1 && wdata[BIT_TO1];
    cmd.clr_to2  = hit_sts2 && wdata[BIT_TO2];
    cmd.clr_boot = hit_sts2 && wdata[BIT_BOOT];
  end

  // control and load storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt    <= 1'b1;
      irq_en  <= 1'b0;
      load    <= LOAD_INIT;
      spare_q <= '0;
    end else begin
      if (hit_ctl) begin
        halt   <= wdata[BIT_HALT];
        irq_en <= wdata[BIT_IRQEN];
      end
      if (hit_init && load_ok) begin
        load    <= wdata[CNT_W-1:0];
        spare_q <= wdata[DATA_W-1:CNT_W];
      end
    end
  end

  // read selection
  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_RLD:  rd_mux = DATA_W'(count);
      OFS_STS1: rd_mux[BIT_TO1] = flags.to1;
      OFS_STS2: begin
        rd_mux[BIT_TO2]  = flags.to2;
        rd_mux[BIT_BOOT] = flags.boot;
      end
      OFS_CTL: begin
        rd_mux[BIT_HALT]  = halt;
        rd_mux[BIT_IRQEN] = irq_en;
      end
      OFS_INIT: rd_mux = {spare_q, load};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rd_mux;
  end
endmodule

// File: rtl/dew_counter.sv
`timescale 1ns/1ps
module dew_counter #(
  parameter int CNT_W    = 10,
  parameter int LOAD_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             halt,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] load,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic step;
  logic at_zero;

  always_comb begin
    step    = tick && !halt;
    at_zero = (count == '0);
    // a software reload on the same edge takes precedence
    expire  = step && at_zero && !rld_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                count <= CNT_W'(LOAD_RST);
    else if (rld_wr || expire) count <= load;
    else if (step)             count <= count - 1'b1;
  end
endmodule

// File: rtl/dew_seq.sv
`timescale 1ns/1ps
module dew_seq
  import dew_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       no_reboot,
  input  dew_cmd_t   cmd,
  output dew_flags_t flags,
  output logic       rst_req
);
  logic second;
  logic fire;

  always_comb begin
    second = expire && flags.to1;
    fire   = second && !no_reboot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      rst_req <= 1'b0;
    end else begin
      // a set on the same edge as a clear wins
      flags.to1  <= expire ? 1'b1 : (flags.to1 && !cmd.clr_to1);
      flags.to2  <= second ? 1'b1 : (flags.to2 && !cmd.clr_to2);
      flags.boot <= fire   ? 1'b1 : (flags.boot && !cmd.clr_boot);
      rst_req    <= fire;
    end
  end
endmodule

// File: rtl/dew_watchdog.sv
`timescale 1ns/1ps
module dew_watchdog
  import dew_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int LOAD_MIN = 4,
  parameter int LOAD_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              no_reboot,
  output logic              irq_o,
  output logic              rst_req_o
);
  dew_cmd_t         cmd;
  dew_flags_t       flags;
  logic             halt;
  logic             irq_en;
  logic [CNT_W-1:0] load;
  logic [CNT_W-1:0] count;
  logic             expire;

  dew_regs #(.CNT_W(CNT_W), .LOAD_MIN(LOAD_MIN), .LOAD_RST(LOAD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .re(bus_re), .count(count), .flags(flags), .cmd(cmd),
    .halt(halt), .irq_en(irq_en), .load(load), .rdata(bus_rdata)
  );

  dew_counter #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .halt(halt),
    .rld_wr(cmd.rld_wr), .load(load), .count(count), .expire(expire)
  );

  dew_seq u_seq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .no_reboot(no_reboot),
    .cmd(cmd), .flags(flags), .rst_req(rst_req_o)
  );

  assign irq_o = flags.to1 && irq_en;
endmodule

// File: rtl/dew_checker.sv
`timescale 1ns/1ps
module dew_checker
  import dew_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int LOAD_MIN = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req_o,
  input logic             no_reboot,
  input logic             halt,
  input dew_cmd_t         cmd,
  input dew_flags_t       flags,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] load
);
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  assert_reset_after_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> flags.to2);

  assert_veto_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !$past(no_reboot));

  assert_halt_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !cmd.rld_wr) |=> $stable(count));

  assert_load_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load >= CNT_W'(LOAD_MIN));

  assert_to1_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags.to1) |-> $past(cmd.clr_to1));

  assert_to2_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags.to2) |-> $past(cmd.clr_to2));
endmodule

bind dew_watchdog dew_checker #(.CNT_W(CNT_W), .LOAD_MIN(LOAD_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req_o(rst_req_o), .no_reboot(no_reboot),
  .halt(halt), .cmd(cmd), .flags(flags), .count(count), .load(load)
);

// File: tb/dew_watchdog_tb.sv
`timescale 1ns/1ps
module dew_watchdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic        no_reboot = 1'b0;
  logic        irq_o;
  logic        rst_req_o;

  int n_chk = 0;
  int n_fail = 0;
  int n_rst = 0;
  logic re_q = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  dew_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .no_reboot(no_reboot), .irq_o(irq_o),
    .rst_req_o(rst_req_o)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: read data appears after the edge that sampled bus_re
  always @(posedge clk) re_q <= bus_re;
  always @(negedge clk) begin
    if (rst_req_o) n_rst++;
    if (re_q) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(bus_rdata == e, t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick_en = 1'b1;
    @(negedge clk); bus_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h00, 16'h0004, "R1 count");
    rd(8'h12, 16'h0004, "R1 load");
    rd(8'h08, 16'h0800, "R1 control");
    rd(8'h04, 16'h0000, "R1 status1");
    rd(8'h06, 16'h0000, "R1 status2");
    check(!rst_req_o && !irq_o, "R1 outputs", {14'b0, rst_req_o, irq_o}, 16'h0);
    // R2 halted ticks ignored, then counting
    tick(3);
    rd(8'h00, 16'h0004, "R2 halted");
    wr(8'h08, 16'h0000);
    rd(8'h08, 16'h0000, "R2 control readback");
    tick(2);
    rd(8'h00, 16'h0002, "R2 counting");
    // R3 reload with arbitrary data
    wr(8'h00, 16'hABCD);
    rd(8'h00, 16'h0004, "R3 reload");
    // R4 valid load write
    wr(8'h12, 16'hFC05);
    rd(8'h12, 16'hFC05, "R4 load readback");
    rd(8'h00, 16'h0004, "R4 count untouched");
    // R5 invalid load values dropped
    wr(8'h12, 16'h0403);
    rd(8'h12, 16'hFC05, "R5 load 3 dropped");
    wr(8'h12, 16'h0000);
    rd(8'h12, 16'hFC05, "R5 load 0 dropped");
    wr(8'h00, 16'h0000);
    rd(8'h00, 16'h0005, "R3 reload new value");
    // R6 expiry
    tick(5);
    rd(8'h00, 16'h0000, "R6 at zero");
    rd(8'h04, 16'h0000, "R6 zero sets nothing");
    tick(1);
    rd(8'h00, 16'h0005, "R6 reloaded");
    rd(8'h04, 16'h0008, "R6 first flag");
    check(!irq_o, "R12 irq disabled", {15'b0, irq_o}, 16'h0);
    check(n_rst == 0, "R6 no reset", 16'(n_rst), 16'h0);
    // R12 interrupt enable
    wr(8'h08, 16'h2000);
    check(irq_o, "R12 irq enabled", {15'b0, irq_o}, 16'h1);
    rd(8'h08, 16'h2000, "R2 control bit13");
    // R7 write-one-to-clear
    wr(8'h04, 16'hFFF7);
    rd(8'h04, 16'h0008, "R7 zero write kept");
    wr(8'h04, 16'h0008);
    rd(8'h04, 16'h0000, "R7 cleared");
    check(!irq_o, "R12 irq follows flag", {15'b0, irq_o}, 16'h0);
    // R10 first stage again after clear
    tick(6);
    rd(8'h04, 16'h0008, "R10 flag again");
    rd(8'h06, 16'h0000, "R10 no second");
    check(n_rst == 0, "R10 no reset", 16'(n_rst), 16'h0);
    // R8 second expiry
    tick(6);
    rd(8'h06, 16'h0006, "R8 second and boot");
    check(n_rst == 1, "R8 one pulse", 16'(n_rst), 16'h1);
    rd(8'h00, 16'h0005, "R8 reloaded");
    rd(8'h04, 16'h0008, "R8 flag stays");
    // R11 clears
    wr(8'h06, 16'h0002);
    rd(8'h06, 16'h0004, "R11 clear second");
    wr(8'h06, 16'h0004);
    rd(8'h06, 16'h0000, "R11 clear boot");
    // R9 veto
    no_reboot = 1'b1;
    tick(6);
    rd(8'h06, 16'h0002, "R9 recorded without boot");
    check(n_rst == 1, "R9 reset vetoed", 16'(n_rst), 16'h1);
    no_reboot = 1'b0;
    wr(8'h06, 16'h0002);
    rd(8'h06, 16'h0000, "R11 clear after veto");
    // R13 reload beats tick at zero
    tick(5);
    rd(8'h00, 16'h0000, "R13 at zero");
    wr_tick(8'h00, 16'h0000);
    rd(8'h00, 16'h0005, "R13 reloaded");
    rd(8'h06, 16'h0000, "R13 no expiry");
    check(n_rst == 1, "R13 no reset", 16'(n_rst), 16'h1);
    // R2 halt again, R14 held read data
    wr(8'h08, 16'h0800);
    tick(4);
    rd(8'h00, 16'h0005, "R2 halted again");
    repeat (3) @(negedge clk);
    check(bus_rdata == 16'h0005, "R14 rdata held", bus_rdata, 16'h0005);
    finish_run();
  end
endmodule